// File: doc/BRIEF.md
# Dual PWM Clock Generator

This block derives two independent clock-enable strobes, A and B, from the master clock. PWM channel counters use them to advance. Each strobe is configured by one 16-bit half of a single 32-bit mode register. Within a half, a 4-bit exponent selects a power-of-two prescale tap, and an 8-bit linear divisor counts that many tap pulses. The tick period is therefore 2^exponent × divisor master-clock cycles.

A free-running prescale counter is shared by both generators and supplies every power-of-two tap. Each generator owns a divide counter. The divide counter advances on the selected tap and emits a one-cycle tick when it wraps. A half that is all zero, or that holds an out-of-range exponent or a zero divisor, leaves its generator idle. Writing a changed value into a half restarts only that generator's divide counter.

All pins are plain control and status pins. There is no streaming interface and no back-pressure: a write is taken on every clock edge where the write strobe is high. The read port always shows the register contents combinationally.

Top module: `dual_pwm_clkgen`

## Requirements
- R1: `rd_data` always equals the 32-bit value taken by the most recent write, including bits [15:12] and [31:28], which have no effect on timing.
- R2: Generator A takes its divisor from bits [7:0] and its exponent from bits [11:8]. In steady state, `clka_tick` pulses once every 2^exponent × divisor cycles.
- R3: Generator B takes its divisor from bits [23:16] and its exponent from bits [27:24]. In steady state, `clkb_tick` pulses once every 2^exponent × divisor cycles.
- R4: While a generator's 16-bit half is zero, its tick output stays low. The other generator keeps running.
- R5: An exponent of 11 to 15, or a divisor of 0, also keeps that generator idle with its tick output low.
- R6: A write that changes a half restarts that generator. With exponent 0, the first tick is high in the cycle that follows the divisor-th rising edge after the write edge. With exponent e, the delay lies between 2^e × (divisor − 1) + 1 and 2^e × divisor cycles.
- R7: A write that leaves a half unchanged does not disturb that generator's tick phase.
- R8: Each tick is high for exactly one cycle. Two ticks fall in consecutive cycles only when the period is 1.
- R9: After the synchronous reset, the register reads 0 and neither tick output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_data | input | 32 | Value written to the mode register |
| rd_data | output | 32 | Current mode register contents |
| clka_tick | output | 1 | One-cycle enable strobe of generator A |
| clkb_tick | output | 1 | One-cycle enable strobe of generator B |

## Verification
The bench builds the block with its default parameters: 8-bit divisors, 4-bit exponents and a highest valid exponent of 10. With these values, the largest exponent (period 1024 with divisor 1) and the largest divisor (period 255 with exponent 0) each fall within the cycle budget, and exponents 11 and 15 exercise the idle decode. Because the exponent field is 4 bits wide, out-of-range exponent codes can be written, which tests the boundary between exponent 10 and exponent 11.

// File: rtl/dual_pwm_clkgen_pkg.sv
`timescale 1ns/1ps
package dual_pwm_clkgen_pkg;
  localparam int unsigned NUM_GEN = 2;
  typedef enum int unsigned {
    GEN_A = 0,
    GEN_B = 1
  } gen_id_e;
endpackage

// File: rtl/dpc_prescaler.sv
`timescale 1ns/1ps
module dpc_prescaler #(
  parameter int unsigned MAX_EXP = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic [MAX_EXP:0] strobe_o
);
  logic [MAX_EXP-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o[0] = 1'b1;
  for (genvar k = 1; k <= MAX_EXP; k++) begin : g_tap
    assign strobe_o[k] = &cnt_q[k-1:0];
  end
endmodule

// File: rtl/dpc_mode_reg.sv
`timescale 1ns/1ps
module dpc_mode_reg #(
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned NUM_GEN = 2,
  localparam int unsigned REG_W  = HALF_W * NUM_GEN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   mode_o,
  output logic [NUM_GEN-1:0] restart_o
);
  logic [REG_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)        mode_q <= '0;
    else if (wr_en) mode_q <= wr_data;
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_restart
    assign restart_o[g] = wr_en &&
      (wr_data[g*HALF_W +: HALF_W] != mode_q[g*HALF_W +: HALF_W]);
  end

  assign mode_o = mode_q;

  // R1: the register takes the written word
  a_r1_readback: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mode_o == $past(wr_data)));
  // R7: without a write the contents are kept
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mode_o));
endmodule

// File: rtl/dpc_divider.sv
`timescale 1ns/1ps
module dpc_divider #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned MAX_EXP = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAX_EXP:0] strobe_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic             active;
  logic             step;
  logic             last;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  assign active = (div_i != '0) && (int'(exp_i) <= int'(MAX_EXP));
  assign last   = (cnt_q == div_i - 1'b1);

  always_comb begin
    step = 1'b0;
    for (int k = 0; k <= int'(MAX_EXP); k++) begin
      if (int'(exp_i) == k) step = strobe_i[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= active && step && last;
      if (active && step) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  // R2/R3: the divide count never reaches the divisor while live
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q < div_i));
  // R5: out-of-range exponent yields no tick
  a_r5_exp_idle: assert property (@(posedge clk) disable iff (rst)
    (int'(exp_i) > int'(MAX_EXP)) |=> !tick_o);
  // R8: back-to-back ticks only with period one
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (tick_o && ((div_i > 1) || (exp_i != '0))) |=> !tick_o);
endmodule

// File: rtl/dual_pwm_clkgen.sv
`timescale 1ns/1ps
module dual_pwm_clkgen
  import dual_pwm_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned MAX_EXP = 10,
  parameter int unsigned HALF_W  = 16,
  localparam int unsigned REG_W  = HALF_W * NUM_GEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clka_tick,
  output logic             clkb_tick
);
  logic [REG_W-1:0]   mode;
  logic [NUM_GEN-1:0] restart;
  logic [NUM_GEN-1:0] tick_vec;
  logic [MAX_EXP:0]   strobe;

  dpc_mode_reg #(.HALF_W(HALF_W), .NUM_GEN(NUM_GEN)) i_mode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .mode_o(mode), .restart_o(restart)
  );

  dpc_prescaler #(.MAX_EXP(MAX_EXP)) i_pre (
    .clk(clk), .rst(rst), .strobe_o(strobe)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    dpc_divider #(.DIV_W(DIV_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) i_div (
      .clk(clk), .rst(rst), .strobe_i(strobe),
      .div_i(mode[g*HALF_W +: DIV_W]),
      .exp_i(mode[g*HALF_W + DIV_W +: EXP_W]),
      .restart_i(restart[g]),
      .tick_o(tick_vec[g])
    );

    // R4: a zero half never ticks
    a_r4_zero_half_idle: assert property (@(posedge clk) disable iff (rst)
      (mode[g*HALF_W +: HALF_W] == '0) |=> !tick_vec[g]);
  end

  assign rd_data   = mode;
  assign clka_tick = tick_vec[GEN_A];
  assign clkb_tick = tick_vec[GEN_B];

  // R9: no tick directly after reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (tick_vec == '0));
endmodule

// File: tb/test_dual_pwm_clkgen.sv
`timescale 1ns/1ps
module test_dual_pwm_clkgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clka_tick, clkb_tick;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_pwm_clkgen i_dual_pwm_clkgen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clka_tick(clka_tick), .clkb_tick(clkb_tick)
  );

  // {expA[3:0], divA[7:0], expB[3:0], divB[7:0]}
  localparam logic [23:0] VEC [0:5] = '{
    24'h0_01_0_02, 24'h0_07_1_03, 24'h2_05_3_01,
    24'hA_01_0_FF, 24'h4_09_5_02, 24'h1_FF_2_64
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic pick(input bit sel_b);
    return sel_b ? clkb_tick : clka_tick;
  endfunction

  // called at a negedge; returns negedges until tick seen (0 = now)
  task automatic wait_tick(input bit sel_b, output int n);
    n = 0;
    while (!pick(sel_b) && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(input bit sel_b, output int per);
    int n;
    wait_tick(sel_b, n);
    per = 0;
    do begin
      @(negedge clk);
      per++;
    end while (!pick(sel_b) && per < 3000);
  endtask

  task automatic count_ticks(input int n, output int ca, output int cb);
    ca = 0;
    cb = 0;
    repeat (n) begin
      @(negedge clk);
      ca += int'(clka_tick);
      cb += int'(clkb_tick);
    end
  endtask

  initial begin
    int ca, cb, per, n, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 rd_data after reset", int'(rd_data), 0);
    count_ticks(64, ca, cb);
    check("R9 A quiet after reset", ca, 0);
    check("R9 B quiet after reset", cb, 0);

    // R2 / R3: table of periods
    for (int i = 0; i < 6; i++) begin
      logic [3:0] ea, eb;
      logic [7:0] da, db;
      {ea, da, eb, db} = VEC[i];
      write_reg({4'h0, eb, db, 4'h0, ea, da});
      measure(1'b0, per);
      check("R2 A period", per, (1 << ea) * int'(da));
      measure(1'b1, per);
      check("R3 B period", per, (1 << eb) * int'(db));
    end

    // R1: readback including unused bits; bits 15:12 ignored for timing
    write_reg(32'hA5C3_F00D);
    check("R1 readback", int'(rd_data == 32'hA5C3_F00D), 1);
    measure(1'b0, per);
    check("R1 upper bits ignored, A period", per, 13);

    // R4: zero half idle, other runs
    write_reg(32'h0000_0204);
    count_ticks(300, ca, cb);
    check("R4 B zero half idle", cb, 0);
    check("R4 A still runs", int'(ca >= 18), 1);
    write_reg(32'h0103_0000);
    count_ticks(300, ca, cb);
    check("R4 A zero half idle", ca, 0);
    check("R4 B still runs", int'(cb >= 49), 1);

    // R5: exponent 11 / 15 and zero divisor idle
    write_reg(32'h0F03_0B01);
    count_ticks(2100, ca, cb);
    check("R5 A exponent 11 idle", ca, 0);
    check("R5 B exponent 15 idle", cb, 0);
    write_reg(32'h0000_0200);
    count_ticks(100, ca, cb);
    check("R5 A divisor 0 idle", ca, 0);

    // R6: restart on change
    write_reg(32'h0000_0003);
    write_reg(32'h0000_000A);
    wait_tick(1'b0, n);
    check("R6 first tick delay d=10", n, 10);
    write_reg(32'h0000_000A);
    repeat (4) @(negedge clk);
    write_reg(32'h0000_0006);
    wait_tick(1'b0, n);
    check("R6 mid-count restart d=6", n, 6);
    write_reg(32'h0000_0205);
    wait_tick(1'b0, n);
    check("R6 first tick window e=2 d=5", int'(n >= 17 && n <= 20), 1);

    // R7: unchanged half keeps phase
    write_reg(32'h0004_0003);
    wait_tick(1'b0, n);
    @(negedge clk);
    wait_tick(1'b0, n);
    c0 = cyc;
    write_reg(32'h0007_0003);
    wait_tick(1'b0, n);
    check("R7 A phase kept across B write", cyc - c0, 3);

    // R8: pulse width
    write_reg(32'h0000_0001);
    @(negedge clk);
    count_ticks(10, ca, cb);
    check("R8 period one continuous", ca, 10);
    write_reg(32'h0000_0002);
    count_ticks(10, ca, cb);
    check("R8 period two alternates", ca, 5);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule